// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is the data register that a JTAG TAP controller selects when a host wants to reach the debug registers of an embedded processor core. It is 38 bits long. The low 32 bits carry a data word, the next five bits carry a register number, and the top bit is a direction flag. The TAP controller supplies one-cycle capture, shift and update strobes together with TDI, and the block drives TDO. On the inside, the block drives a small strobe bus toward the register bank: an address, a write strobe with write data, and a read strobe that returns data in the same cycle.

A write takes one scan and takes effect when the scan is committed. A read takes two scans. The first scan leaves a register number and the read flag in the latch. The next capture fetches that register, and the scan after that shifts the value out. Some registers lose their contents when they are read, such as the inbound word of the communication channel. For these, the host must end its last read with a harmless register number left in the latch, so that a later capture does not consume another word. The block checks the register number against a fixed map, so that narrow registers never see or return bits above their width and unmapped numbers are inert.

Top module: `dbg_scan_chain`

## Requirements
- R1: Bits leave on `tdo` least significant first. After a capture, `tdo` shows captured bit 0, and each shift then moves the next higher bit out while `tdi` enters at bit 37. Thirty-eight shifts after a capture return the whole captured word, and the next 38 shifts return the bits that went in.
- R2: When the update strobe arrives with bit 37 = 1 and a mapped register number in bits 36:32, exactly one `bus_wr` pulse is issued in that cycle, with `bus_addr` = bits 36:32 and `bus_wdata` = bits 31:0.
- R3: When the update strobe arrives with bit 37 = 0, no bus strobe is issued and only the register number and flag are latched. The next capture issues exactly one `bus_rd` pulse at the latched number and loads the returned value into bits 31:0.
- R4: Narrow registers are right-aligned, and bits above their width are zero in both write data and captured data. The widths are: 0 (debug control) CTL_W, default 6; 1 (debug status) STS_W, default 5; 2 (vector catch) 8; 4 (channel control) 6; 5 (channel data) 32; 8–11 and 16–19 32; 12 and 20 (watch control value) 9; 13 and 21 (watch control mask) 8.
- R5: Register numbers 3, 6, 7, 14, 15 and 22–31 are unmapped. Writes to them issue no strobe, and a capture after a read scan of one of them loads zero data without a strobe.
- R6: Capture and shift never change the latched register number or flag, and a shift cycle issues no bus strobe.
- R7: Reset clears the chain to zero and latches register 0 with the read flag, so that the first capture after reset reads register 0.
- R8: Every capture loads bits 37:32 with the latched flag and register number. After a write scan, the capture loads zero data and issues no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the latch |
| rst_n | input | 1 | Active-low reset (test reset or functional reset) |
| capture_en | input | 1 | Capture strobe from the TAP controller |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| update_en | input | 1 | Update strobe that commits the scan |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, chain bit 0 |
| bus_addr | output | 5 | Register number on the bank bus |
| bus_wr | output | 1 | Write strobe to the register bank |
| bus_wdata | output | 32 | Write data, masked to the register width |
| bus_rd | output | 1 | Read strobe to the register bank |
| bus_rdata | input | 32 | Read data returned in the same cycle as `bus_rd` |

## Verification
The hardest case to reach is the destructive read. The strobe for the channel data register comes from a capture that is one scan removed from the scan that selected it. A read that consumes a word twice is therefore visible only across three consecutive scans. The stimulus selects register 5 with the read flag, follows with a scan that moves the latch to register 4, and checks that exactly one read pulse landed on register 5. It also checks that the next capture shows register 4's masked value. The model tracks the latch through partial scans, scans that are never committed, and resets taken mid-sequence, so that every capture predicts which register is read.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;

    localparam int unsigned ADDR_W = 5;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // width of the register at a given number; zero marks an unmapped number
    function automatic int unsigned field_width(
        input logic [ADDR_W-1:0] num,
        input int unsigned       ctl_w,
        input int unsigned       sts_w
    );
        logic [2:0] slot;
        slot = num[2:0];
        case (num[4:3])
            2'd0: begin
                case (slot)
                    3'd0:    return ctl_w;
                    3'd1:    return sts_w;
                    3'd2:    return 8;
                    3'd4:    return 6;
                    3'd5:    return 32;
                    default: return 0;
                endcase
            end
            2'd1, 2'd2: begin
                case (slot)
                    3'd0, 3'd1, 3'd2, 3'd3: return 32;
                    3'd4:    return 9;
                    3'd5:    return 8;
                    default: return 0;
                endcase
            end
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dbgscan_decode.sv
module dbgscan_decode
    import dbgscan_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTL_W  = 6,
    parameter int unsigned STS_W  = 5
) (
    input  logic [ADDR_W-1:0] num,
    output logic              hit,
    output logic [DATA_W-1:0] keep
);

    logic [31:0] width;

    assign width = field_width(num, CTL_W, STS_W);
    assign hit   = (width != 32'd0);

    for (genvar g = 0; g < DATA_W; g++) begin : g_keep
        assign keep[g] = (width > g);
    end

endmodule

// File: rtl/dbgscan_shreg.sv
module dbgscan_shreg #(
    parameter int unsigned W = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         tdi,
    output logic [W-1:0] q
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_val;
        end else if (shift) begin
            sr_d = {tdi, sr_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign q = sr_q;

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbgscan_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTL_W  = 6,
    parameter int unsigned STS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned CHAIN_W = DATA_W + ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        dir_e              dir;
    } latch_t;

    latch_t lat_d, lat_q;

    logic [CHAIN_W-1:0] sr_q;
    logic [CHAIN_W-1:0] cap_val;
    logic [ADDR_W-1:0]  sr_addr;
    logic               sr_dir;
    logic               upd_hit, lat_hit;
    logic [DATA_W-1:0]  upd_keep, lat_keep;
    logic               rd_fire, wr_fire;

    assign sr_addr = sr_q[DATA_W +: ADDR_W];
    assign sr_dir  = sr_q[CHAIN_W-1];

    dbgscan_decode #(.DATA_W(DATA_W), .CTL_W(CTL_W), .STS_W(STS_W)) u_dec_upd (
        .num  (sr_addr),
        .hit  (upd_hit),
        .keep (upd_keep)
    );

    dbgscan_decode #(.DATA_W(DATA_W), .CTL_W(CTL_W), .STS_W(STS_W)) u_dec_lat (
        .num  (lat_q.addr),
        .hit  (lat_hit),
        .keep (lat_keep)
    );

    // read happens at capture, against the number left by the previous scan
    assign rd_fire = capture_en && (lat_q.dir == DIR_READ) && lat_hit;
    assign wr_fire = update_en && sr_dir && upd_hit;

    assign cap_val = {lat_q.dir, lat_q.addr,
                      rd_fire ? (bus_rdata & lat_keep) : {DATA_W{1'b0}}};

    dbgscan_shreg #(.W(CHAIN_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture_en),
        .load_val (cap_val),
        .shift    (shift_en),
        .tdi      (tdi),
        .q        (sr_q)
    );

    always_comb begin
        lat_d = lat_q;
        if (update_en) begin
            lat_d.addr = sr_addr;
            lat_d.dir  = dir_e'(sr_dir);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '{addr: '0, dir: DIR_READ};
        end else begin
            lat_q <= lat_d;
        end
    end

    assign tdo       = sr_q[0];
    assign bus_addr  = update_en ? sr_addr : lat_q.addr;
    assign bus_wr    = wr_fire;
    assign bus_rd    = rd_fire;
    assign bus_wdata = sr_q[DATA_W-1:0] & upd_keep;

endmodule

// File: rtl/dbgscan_check.sv
module dbgscan_check #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              capture_en,
    input logic              shift_en,
    input logic              update_en,
    input logic [4:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [4:0]        lat_addr
);

    a_r2_write_at_update: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> update_en);

    a_r3_read_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> capture_en);

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    a_r4_ctrl_value_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 5'd12 || bus_addr == 5'd20)) |-> ((bus_wdata >> 9) == '0));

    a_r4_ctrl_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 5'd13 || bus_addr == 5'd21 || bus_addr == 5'd2))
            |-> ((bus_wdata >> 8) == '0));

    a_r5_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> !(bus_addr == 5'd3 || bus_addr == 5'd6 || bus_addr == 5'd7 ||
                                 bus_addr == 5'd14 || bus_addr == 5'd15 || bus_addr >= 5'd22));

    a_r6_shift_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !update_en) |=> $stable(lat_addr));

    a_r6_shift_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !update_en && !capture_en) |-> (!bus_wr && !bus_rd));

    a_r7_reset_latch: assert property (@(posedge clk)
        $rose(rst_n) |-> (lat_addr == 5'd0));

endmodule

bind dbg_scan_chain dbgscan_check #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .lat_addr   (lat_q.addr)
);

// File: tb/test_dbg_scan_chain.sv
module test_dbg_scan_chain;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [4:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_seen = 0;
    int rd5_seen = 0;
    string tag = "R7";

    // reference model state
    bit     chain[$];
    int     m_addr;
    bit     m_wr;

    always #10 clk = ~clk;

    dbg_scan_chain i_dbg_scan_chain (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] raw_val(input int a);
        return 32'hF3C5_A96E ^ (a * 32'h0101_0101);
    endfunction

    always_comb bus_rdata = raw_val(int'(bus_addr));

    function automatic int bw(input int a);
        case (a)
            0: return 6;   1: return 5;   2: return 8;   4: return 6;   5: return 32;
            8, 9, 10, 11, 16, 17, 18, 19: return 32;
            12, 20: return 9;
            13, 21: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] masked(input int a, input logic [31:0] v);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < bw(a); i++) r[i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        chain.delete();
        for (int i = 0; i < 38; i++) chain.push_back(1'b0);
        m_addr = 0;
        m_wr   = 1'b0;
    endtask

    // one clock: drive at negedge, compare mid-low phase, advance model
    task automatic cycle(input bit c, input bit s, input bit u, input bit t, output bit o);
        int  ca;
        bit  e_rd, e_wr;
        logic [31:0] cd;
        @(negedge clk);
        capture_en = c; shift_en = s; update_en = u; tdi = t;
        #5;
        o  = tdo;
        ca = 0;
        for (int i = 0; i < 5; i++) ca += int'(chain[32+i]) << i;
        cd = '0;
        for (int i = 0; i < 32; i++) cd[i] = chain[i];
        e_rd = c && !m_wr && bw(m_addr) != 0;
        e_wr = u && chain[37] && bw(ca) != 0;
        check({tag, " tdo"}, 64'(tdo), 64'(chain[0]));
        check({tag, " bus_rd"}, 64'(bus_rd), 64'(e_rd));
        check({tag, " bus_wr"}, 64'(bus_wr), 64'(e_wr));
        if (e_rd) begin
            check({tag, " rd addr"}, 64'(bus_addr), 64'(m_addr));
        end
        if (e_wr) begin
            check({tag, " wr addr"}, 64'(bus_addr), 64'(ca));
            check({tag, " wr data"}, 64'(bus_wdata), 64'(masked(ca, cd)));
        end
        if (bus_rd) begin
            rd_seen++;
            if (bus_addr == 5'd5) rd5_seen++;
        end
        // advance model
        if (c) begin
            logic [31:0] d;
            d = e_rd ? masked(m_addr, raw_val(m_addr)) : 32'h0;
            chain.delete();
            for (int i = 0; i < 32; i++) chain.push_back(d[i]);
            for (int i = 0; i < 5; i++) chain.push_back(bit'((m_addr >> i) & 1));
            chain.push_back(m_wr);
        end else if (s) begin
            void'(chain.pop_front());
            chain.push_back(t);
        end
        if (u) begin
            m_addr = ca;
            m_wr   = chain[37];
            // model update uses pre-edge chain contents
        end
    endtask

    // full scan: capture, 38 shifts, update; returns captured word
    task automatic scan(input bit wr, input int a, input logic [31:0] d, output logic [37:0] got);
        logic [37:0] pay;
        bit o;
        pay = {wr, 5'(a), d};
        cycle(1, 0, 0, 0, o);
        for (int i = 0; i < 38; i++) begin
            cycle(0, 1, 0, pay[i], o);
            got[i] = o;
        end
        cycle(0, 0, 1, 0, o);
        cycle(0, 0, 0, 0, o);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; capture_en = 0; shift_en = 0; update_en = 0; tdi = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [37:0] got;
        logic [37:0] pay;
        bit o;
        int rd_before;

        model_reset();
        repeat (3) @(negedge clk);
        #5;
        tag = "R7";
        check("R7 tdo in reset", 64'(tdo), 64'd0);
        check("R7 strobes in reset", 64'({bus_wr, bus_rd}), 64'd0);
        rst_n = 1'b1;

        // R7: first capture after reset reads register 0
        scan(0, 5, 32'h0, got);
        check("R7 first capture", 64'(got), 64'({1'b0, 5'd0, masked(0, raw_val(0))}));

        // R3 / R4: capture of channel data; then move latch to channel control
        tag = "R3";
        rd_before = rd5_seen;
        scan(0, 4, 32'h0, got);
        check("R3 read data", 64'(got), 64'({1'b0, 5'd5, raw_val(5)}));
        check("R3 single consume", 64'(rd5_seen - rd_before), 64'd1);
        tag = "R4";
        scan(1, 8, 32'h1234_5678, got);
        check("R4 ctrl read masked", 64'(got), 64'({1'b0, 5'd4, masked(4, raw_val(4))}));

        // R2 / R8: write then capture shows zero data, flag and number echoed
        tag = "R8";
        rd_before = rd_seen;
        scan(1, 12, 32'hFFFF_FFFF, got);
        check("R8 capture after write", 64'(got), 64'({1'b1, 5'd8, 32'h0}));
        check("R8 no read after write", 64'(rd_seen - rd_before), 64'd0);
        tag = "R4";
        scan(1, 21, 32'hFFFF_FFFF, got);
        check("R4 echo after ctrl write", 64'(got), 64'({1'b1, 5'd12, 32'h0}));
        tag = "R2";
        scan(1, 17, 32'hA5A5_0F0F, got);
        scan(0, 20, 32'h0, got);

        // R4: watch control value read masked to 9 bits
        tag = "R4";
        scan(0, 13, 32'h0, got);
        check("R4 ctrl value read", 64'(got), 64'({1'b0, 5'd20, masked(20, raw_val(20))}));
        scan(0, 1, 32'h0, got);
        check("R4 ctrl mask read", 64'(got), 64'({1'b0, 5'd13, masked(13, raw_val(13))}));
        scan(0, 2, 32'h0, got);
        check("R4 status read", 64'(got), 64'({1'b0, 5'd1, masked(1, raw_val(1))}));

        // R5: unmapped write and read
        tag = "R5";
        scan(1, 3, 32'hFFFF_FFFF, got);
        check("R5 vector catch read", 64'(got), 64'({1'b0, 5'd2, masked(2, raw_val(2))}));
        rd_before = rd_seen;
        scan(0, 25, 32'h0, got);
        scan(0, 6, 32'h0, got);
        check("R5 unmapped reads zero", 64'(got), 64'({1'b0, 5'd25, 32'h0}));
        check("R5 no strobe", 64'(rd_seen - rd_before), 64'd0);

        // R6: shifting without update leaves latch alone (latch holds 6)
        tag = "R6";
        cycle(1, 0, 0, 0, o);
        for (int i = 0; i < 50; i++) cycle(0, 1, 0, 1'b1, o);
        pay = {1'b0, 5'd9, 32'h0};
        scan(0, 9, 32'h0, got);
        check("R6 latch unchanged by shift", 64'(got[37:32]), 64'({1'b0, 5'd6}));

        // R1: pass-through order, LSB first
        tag = "R1";
        pay = {1'b1, 5'd19, 32'hC0DE_1234};
        cycle(1, 0, 0, 0, o);
        for (int i = 0; i < 76; i++) begin
            cycle(0, 1, 0, pay[i % 38], o);
            if (i < 38) got[i] = o;
            else begin
                check("R1 pass-through bit", 64'(o), 64'(pay[i - 38]));
            end
        end
        check("R1 captured order", 64'(got), 64'({1'b0, 5'd9, masked(9, raw_val(9))}));
        cycle(0, 0, 1, 0, o);

        // R7: reset mid-sequence clears latch (was a write to 19)
        tag = "R7";
        do_reset();
        scan(0, 0, 32'h0, got);
        check("R7 latch after reset", 64'(got), 64'({1'b0, 5'd0, masked(0, raw_val(0))}));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule